// File: doc/BRIEF.md
# Fractional-Rate Realtime Master Counter

This block keeps a free-running 64-bit count that advances at one fixed nominal rate, 6.144 MHz on average, whatever the frequency of the clock that drives it. On every edge of its source clock it adds a programmable numerator to an error accumulator. Each time the accumulator reaches the denominator, the denominator is taken off and the count goes up by one, so the count advances by numerator/denominator per source clock.

A 3-bit clock-select input names the frequency of the present source clock, and the block loads a matching default ratio whenever that code changes to a known frequency. Software can also set the ratio through two registers. The values written there are only staged, and a dedicated bit in the denominator register moves them into the live accumulator logic on a single edge, with the accumulator residue kept. The count is read as two 32-bit words, and a read of the low word captures the high word so that the pair is coherent.

Top module: `frac_rate_counter`

## Requirements
- R1: On a clock edge with `rst_n` low, the count and accumulator become 0, and the staged and live ratio take the default for `clk_sel`. Codes 0 and 3 fall back to 1664/3250 at reset. The register extra bits become 0.
- R2: On every edge out of reset, the live numerator is added to the accumulator. If the sum is at least the live denominator, the denominator is subtracted and the count rises by exactly one. The count never rises by more than one per edge, so over 3250 edges from reset with code 1 it advances by exactly 1664.
- R3: Default ratios by `clk_sel` code: 1 → 1664/3250, 2 → 1536/3250, 4 → 1040/3250, 5 → 768/3250, 6 → 768/3375, 7 → 520/3250.
- R4: When `clk_sel` differs from its previous value and is a valid code, the staged and live ratio take that code's default on that edge. That edge still accumulates with the old ratio.
- R5: A change of `clk_sel` to code 0 or 3 leaves the live and staged ratio unchanged.
- R6: Register 0x10 holds the staged numerator in bits [11:0] and register 0x14 holds the staged denominator in bits [11:0]. Bits [31:12] of both are stored and read back as written. Bit 16 of 0x14 always reads 0.
- R7: A write to 0x14 with bit 16 set copies the staged numerator and the written denominator into the live ratio on that edge. The accumulator residue is kept, and the new ratio applies from the next edge.
- R8: A write to 0x14 whose bits [11:0] are zero is ignored entirely: the register and the live ratio keep their values.
- R9: A reload whose staged numerator is not below the written denominator leaves the live ratio unchanged, although register 0x14 is still updated.
- R10: Address 0x00 reads count[31:0], and 0x04 reads the high word captured by the last `rd_en` read of 0x00. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 3 | Code naming the present source clock frequency |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe (captures the high word when reading 0x00) |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| count_o | output | 64 | Live count |

## Verification
Every clock-select code, including the two unused ones, is run from reset over a full denominator period and over short runs. The full-period runs tell an exact ratio apart from an off-by-one compare. The short runs tell a correct remainder apart from rounding. Further runs switch the ratio mid-run by register reload and by a `clk_sel` change, and the totals there depend on how many edges used each ratio, so a reload that is late, early or resets the residue gives a different count. Rejected writes (zero denominator, ratio not below one, unused code) are followed by a full period whose count shows whether the live ratio moved.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;

  localparam int RATIO_W = 12;

  typedef struct packed {
    logic [RATIO_W-1:0] num;
    logic [RATIO_W-1:0] den;
  } ratio_t;

  // R3: codes 0 and 3 carry no frequency; callers treat them as invalid
  function automatic logic ratio_code_valid(input logic [2:0] code);
    return !(code == 3'd0 || code == 3'd3);
  endfunction

  // R3 table; invalid codes return the code-1 ratio used as reset fallback (R1)
  function automatic ratio_t default_ratio(input logic [2:0] code);
    ratio_t r;
    case (code)
      3'd2:    r = '{num: 12'd1536, den: 12'd3250};
      3'd4:    r = '{num: 12'd1040, den: 12'd3250};
      3'd5:    r = '{num: 12'd768,  den: 12'd3250};
      3'd6:    r = '{num: 12'd768,  den: 12'd3375};
      3'd7:    r = '{num: 12'd520,  den: 12'd3250};
      default: r = '{num: 12'd1664, den: 12'd3250};
    endcase
    return r;
  endfunction

  // R2: one Bresenham step; returns {carry, next residue}
  function automatic logic [RATIO_W+1:0] bres_step(input logic [RATIO_W:0]   acc,
                                                   input logic [RATIO_W-1:0] num,
                                                   input logic [RATIO_W-1:0] den);
    logic [RATIO_W:0] sum;
    sum = acc + {1'b0, num};
    if (sum >= {1'b0, den}) return {1'b1, sum - {1'b0, den}};
    return {1'b0, sum};
  endfunction

endpackage

// File: rtl/frac_ratio_regs.sv
module frac_ratio_regs
  import frac_rate_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int RELOAD_BIT = 16,
  parameter logic [ADDR_W-1:0] NUM_OFF = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_OFF = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        clk_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] num_reg_q,
  output logic [DATA_W-1:0] den_reg_q,
  output ratio_t            live_q,
  output logic              reload_fire,
  output logic              sel_load
);

  localparam logic [DATA_W-1:0] RELOAD_MASK = DATA_W'(1) << RELOAD_BIT;

  logic [2:0]         sel_q;
  ratio_t             dflt;
  logic               wr_num, wr_den, den_zero, den_accept, reload_req;
  logic [RATIO_W-1:0] den_wr_val;

  assign dflt        = default_ratio(clk_sel);
  assign wr_num      = wr_en && (addr == NUM_OFF);
  assign wr_den      = wr_en && (addr == DEN_OFF);
  assign den_wr_val  = wdata[RATIO_W-1:0];
  assign den_zero    = (den_wr_val == '0);
  assign den_accept  = wr_den && !den_zero;
  assign reload_req  = den_accept && wdata[RELOAD_BIT];
  assign reload_fire = reload_req && (num_reg_q[RATIO_W-1:0] < den_wr_val);
  assign sel_load    = (clk_sel != sel_q) && ratio_code_valid(clk_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= clk_sel;
      num_reg_q <= DATA_W'(dflt.num);
      den_reg_q <= DATA_W'(dflt.den);
      live_q    <= dflt;
    end else begin
      sel_q <= clk_sel;
      if (sel_load) begin
        num_reg_q[RATIO_W-1:0] <= dflt.num;
        den_reg_q[RATIO_W-1:0] <= dflt.den;
        live_q                 <= dflt;
      end
      if (wr_num)      num_reg_q <= wdata;
      if (den_accept)  den_reg_q <= wdata & ~RELOAD_MASK;
      if (reload_fire) live_q    <= '{num: num_reg_q[RATIO_W-1:0], den: den_wr_val};
    end
  end

  a_r7_reload_takes_live: assert property (@(posedge clk) disable iff (!rst_n)
    reload_fire |=> (live_q.den == $past(wdata[RATIO_W-1:0])) &&
                    (live_q.num == $past(num_reg_q[RATIO_W-1:0])));

  a_r8_zero_den_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_den && den_zero && !sel_load) |=> ($stable(den_reg_q) && $stable(live_q)));

  a_r5_unused_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ratio_code_valid(clk_sel) && !reload_fire) |=> $stable(live_q));

  a_r9_bad_ratio_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_req && !sel_load && (num_reg_q[RATIO_W-1:0] >= den_wr_val)) |=> $stable(live_q));

endmodule

// File: rtl/frac_accum.sv
module frac_accum
  import frac_rate_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ratio_t           live,
  output logic [CNT_W-1:0] count_q,
  output logic             step
);

  logic [RATIO_W:0]   acc_q;
  logic [RATIO_W+1:0] nxt;

  assign nxt  = bres_step(acc_q, live.num, live.den);
  assign step = nxt[RATIO_W+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      count_q <= '0;
    end else begin
      acc_q   <= nxt[RATIO_W:0];
      count_q <= count_q + CNT_W'(step);
    end
  end

  a_r2_one_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_q == $past(count_q) + CNT_W'($past(step))));

  a_r2_residue_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (acc_q < {1'b0, {RATIO_W{1'b1}}}));

endmodule

// File: rtl/frac_rate_counter.sv
module frac_rate_counter
  import frac_rate_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        clk_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count_o
);

  localparam logic [ADDR_W-1:0] LO_OFF  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] HI_OFF  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] NUM_OFF = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] DEN_OFF = ADDR_W'(8'h14);
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] num_reg_q, den_reg_q;
  ratio_t            live_q;
  logic              reload_fire, sel_load, step;
  logic [HI_W-1:0]   hi_q;
  logic              rd_lo;

  frac_ratio_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RELOAD_BIT(16),
    .NUM_OFF(NUM_OFF), .DEN_OFF(DEN_OFF)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .num_reg_q(num_reg_q), .den_reg_q(den_reg_q),
    .live_q(live_q), .reload_fire(reload_fire), .sel_load(sel_load)
  );

  frac_accum #(.CNT_W(CNT_W)) i_accum (
    .clk(clk), .rst_n(rst_n), .live(live_q), .count_q(count_o), .step(step)
  );

  assign rd_lo = rd_en && (addr == LO_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_q <= '0;
    else if (rd_lo) hi_q <= count_o[CNT_W-1:DATA_W];
  end

  always_comb begin
    case (addr)
      LO_OFF:  rdata = count_o[DATA_W-1:0];
      HI_OFF:  rdata = DATA_W'(hi_q);
      NUM_OFF: rdata = num_reg_q;
      DEN_OFF: rdata = den_reg_q;
      default: rdata = '0;
    endcase
  end

  a_r10_high_word_captured: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (hi_q == $past(count_o[CNT_W-1:DATA_W])));

endmodule

// File: tb/test_frac_rate_counter.sv
module test_frac_rate_counter;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam int TV_SEL [NV] = '{1, 2, 4, 5, 6, 7, 0, 3, 6, 1};
  localparam int TV_CYC [NV] = '{3250, 3250, 3250, 3250, 3375, 3250, 3250, 3250, 1000, 100};
  localparam int TV_EXP [NV] = '{1664, 1536, 1040, 768, 768, 520, 1664, 1664, 227, 51};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  clk_sel = 3'd1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] count_o;

  int checks = 0, failures = 0;

  frac_rate_counter i_frac_rate_counter (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .count_o(count_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint unsigned ref_num(input int s);
    case (s) 2: return 1536; 4: return 1040; 5: return 768; 6: return 768; 7: return 520;
      default: return 1664; endcase
  endfunction

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int s);
    rst_n = 1'b0; clk_sel = 3'(s); wr_en = 0; rd_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] lo;

    // R1 reset state
    do_reset(5);
    chk("R1 count after reset", count_o, 0);
    rd(8'h10, v); chk("R1 staged num", v, 768);
    rd(8'h14, v); chk("R1 staged den", v, 3250);

    // R2 R3 table walk from reset (codes 0 and 3 fall back, R1)
    for (int i = 0; i < NV; i++) begin
      do_reset(TV_SEL[i]);
      run(TV_CYC[i]);
      chk($sformatf("R2/R3 code %0d cycles %0d", TV_SEL[i], TV_CYC[i]), count_o, TV_EXP[i]);
      rd(8'h10, v); chk("R3 default num readback", v, ref_num(TV_SEL[i]));
    end

    // R7 mid-run reload, residue kept; den stays 3250
    do_reset(1);
    run(3250);
    chk("R2 one period code 1", count_o, 1664);
    wr(8'h10, 32'd520);
    wr(8'h14, 32'h0001_0000 | 32'd3250);
    run(3250);
    chk("R7 count across reload", count_o, (1664*3252 + 520*3250) / 3250);

    // R6 extra field bits preserved, reload bit reads 0
    do_reset(1);
    wr(8'h10, 32'hABCD_E680);
    rd(8'h10, v); chk("R6 num reg readback", v, 32'hABCD_E680);
    wr(8'h14, 32'hABC1_0CB2);
    rd(8'h14, v); chk("R6 den reg readback", v, 32'hABC0_0CB2);

    // R8 zero denominator write ignored
    do_reset(1);
    wr(8'h10, 32'd100);
    wr(8'h14, 32'h0001_0000);
    run(3248);
    chk("R8 rate unchanged", count_o, 1664);
    rd(8'h14, v); chk("R8 den reg kept", v, 3250);

    // R9 ratio not below one rejected
    do_reset(1);
    wr(8'h10, 32'd3300);
    wr(8'h14, 32'h0001_0000 | 32'd3250);
    run(3248);
    chk("R9 rate unchanged", count_o, 1664);

    // R4 clk_sel change to valid code mid-run
    do_reset(1);
    run(1625);
    clk_sel = 3'd7;
    run(3250);
    chk("R4 count across select change", count_o, (1664*1626 + 520*3249) / 3250);
    rd(8'h10, v); chk("R4 staged num follows code", v, 520);

    // R5 change to unused code keeps ratio
    do_reset(4);
    run(10);
    clk_sel = 3'd3;
    run(3240);
    chk("R5 rate kept on code 3", count_o, 1040);
    rd(8'h10, v); chk("R5 staged num kept", v, 1040);

    // R10 coherent read pair and unmapped address
    addr = 8'h00; rd_en = 1'b1; #1; lo = rdata;
    chk("R10 low word", lo, count_o[31:0]);
    @(negedge clk); rd_en = 1'b0;
    rd(8'h04, v); chk("R10 captured high word", v, 0);
    rd(8'h08, v); chk("R10 unmapped read", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule